// File: doc/BRIEF.md
# Write-Status Polling Read Responder

This block forms the read side of a byte-wide nonvolatile memory model. On each read it chooses the value the data bus carries. While the array is idle, a read returns the array word unchanged. While an internal programming cycle runs, the read returns a status byte. Software polls that status byte to find out when programming has finished.

The status byte uses three parts. The polling bit is the inverse of bit 7 of the byte written last. The toggle bit changes value once for every new read access. The remaining bits are driven to zero. A read access starts when chip select and output enable are both low, after a cycle in which they were not. A one-bit toggle register counts these starts, but only while the busy flag is set. The register is never cleared at the end of programming, so its phase carries over into the next busy period.

Top module: `poll_resp`

## Requirements
- R1: `drive_en` is 1 exactly when `ce_n` and `oe_n` are both 0. If either input is 1, `drive_en` is 0, and such a partial select does not count as a read access.
- R2: While `prog_busy` is 0, a driven read returns `arr_rdata` on all bits of `rd_data`.
- R3: While `prog_busy` is 1, a driven read returns the inverse of `last_wr_byte[7]` on `rd_data[7]`, for any address.
- R4: While `prog_busy` is 1, `rd_data[6]` takes the opposite value at each new read access and holds that value for the whole access.
- R5: While `prog_busy` is 1, `rd_data[5:0]` is 0 during a driven read.
- R6: Once `prog_busy` returns to 0, reads return true array data, and those reads do not advance the toggle bit.
- R7: The toggle bit keeps its phase from one busy period to the next. The first busy read of a new period shows the inverse of the last toggle value shown.
- R8: Reset clears the toggle bit to 0, so the first busy read after reset shows 1 on `rd_data[6]`.
- R9: While `drive_en` is 0, `rd_data` is all zeros.
- R10: If an access begins while the block is idle and `prog_busy` rises during that access, the toggle bit does not advance; it advances only at the start of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_busy | input | 1 | Programming cycle in progress, from the write controller |
| last_wr_byte | input | DATA_W | Byte most recently written, from the write controller |
| arr_rdata | input | DATA_W | Array word at the current address |
| rd_data | output | DATA_W | Value for the data bus |
| drive_en | output | 1 | Enable for the tristate bus driver |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, the polling bit at position 7, the toggle bit at position 6, and the toggle reset value 0. With these values the bench can check the exact status byte, including the toggle phase right after reset. The bench keeps its own copy of the toggle phase and runs it through several busy periods. Between busy periods it mixes in idle reads and partial selects, and it raises busy in the middle of an access, to show that the phase moves only when a new access starts during busy.

// File: rtl/poll_resp_pkg.sv
package poll_resp_pkg;

   // phase of a bus read access as seen on successive clocks
   typedef enum logic [1:0] {
      ACC_OFF   = 2'd0,
      ACC_START = 2'd1,
      ACC_HOLD  = 2'd2
   } acc_phase_e;

   function automatic logic phase_active(input acc_phase_e p);
      return (p == ACC_START) || (p == ACC_HOLD);
   endfunction

endpackage

// File: rtl/poll_access_track.sv
module poll_access_track
   import poll_resp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_n,
   input  logic       oe_n,
   output acc_phase_e phase
);

   logic sel_now;
   logic sel_prev;

   assign sel_now = ~ce_n & ~oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_prev <= 1'b0;
      else        sel_prev <= sel_now;
   end

   always_comb begin
      if (!sel_now)      phase = ACC_OFF;
      else if (sel_prev) phase = ACC_HOLD;
      else               phase = ACC_START;
   end

endmodule

// File: rtl/poll_toggle_unit.sv
module poll_toggle_unit #(
   parameter logic TOG_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   output logic tog_view
);

   logic tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog_q <= TOG_INIT;
      else if (advance) tog_q <= ~tog_q;
   end

   // the new phase is visible from the first cycle of the access
   assign tog_view = advance ? ~tog_q : tog_q;

endmodule

// File: rtl/poll_status_mux.sv
module poll_status_mux #(
   parameter int   DATA_W   = 8,
   parameter int   POLL_BIT = 7,
   parameter int   TOG_BIT  = 6,
   parameter logic RSVD_VAL = 1'b0
) (
   input  logic              active,
   input  logic              busy,
   input  logic              tog,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [DATA_W-1:0] last_wr_byte,
   output logic [DATA_W-1:0] bus_val
);

   logic [DATA_W-1:0] status_val;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == POLL_BIT) begin : g_poll
         assign status_val[b] = ~last_wr_byte[b];
      end else if (b == TOG_BIT) begin : g_tog
         assign status_val[b] = tog;
      end else begin : g_rsvd
         assign status_val[b] = RSVD_VAL;
      end
   end

   always_comb begin
      if (!active)   bus_val = '0;
      else if (busy) bus_val = status_val;
      else           bus_val = arr_rdata;
   end

endmodule

// File: rtl/poll_resp.sv
module poll_resp
   import poll_resp_pkg::*;
#(
   parameter int   DATA_W   = 8,
   parameter int   POLL_BIT = 7,
   parameter int   TOG_BIT  = 6,
   parameter logic TOG_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              prog_busy,
   input  logic [DATA_W-1:0] last_wr_byte,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              drive_en
);

   localparam int MAX_BIT = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("poll_resp: DATA_W must be at least 2");
   end
   if (POLL_BIT > MAX_BIT || TOG_BIT > MAX_BIT || POLL_BIT < 0 || TOG_BIT < 0) begin : g_bad_pos
      $error("poll_resp: status bit position outside the bus");
   end
   if (POLL_BIT == TOG_BIT) begin : g_bad_overlap
      $error("poll_resp: polling and toggle bits must differ");
   end

   acc_phase_e phase;
   logic       active;
   logic       tog_view;

   poll_access_track u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .oe_n  (oe_n),
      .phase (phase)
   );

   assign active = phase_active(phase);

   poll_toggle_unit #(
      .TOG_INIT (TOG_INIT)
   ) u_tog (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  ((phase == ACC_START) && prog_busy),
      .tog_view (tog_view)
   );

   poll_status_mux #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .TOG_BIT  (TOG_BIT),
      .RSVD_VAL (1'b0)
   ) u_mux (
      .active       (active),
      .busy         (prog_busy),
      .tog          (tog_view),
      .arr_rdata    (arr_rdata),
      .last_wr_byte (last_wr_byte),
      .bus_val      (rd_data)
   );

   assign drive_en = active;

endmodule

// File: rtl/poll_resp_chk.sv
module poll_resp_chk #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TOG_BIT  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              prog_busy,
   input logic [DATA_W-1:0] last_wr_byte,
   input logic [DATA_W-1:0] arr_rdata,
   input logic [DATA_W-1:0] rd_data,
   input logic              drive_en
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R1
   drive_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> !drive_en);

   // R2
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && !prog_busy) |-> rd_data == arr_rdata);

   // R3
   poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && prog_busy) |-> rd_data[POLL_BIT] != last_wr_byte[POLL_BIT]);

   // R4
   tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && drive_en && $past(drive_en) && prog_busy && $past(prog_busy))
         |-> $stable(rd_data[TOG_BIT]));

   // R5
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && prog_busy) |-> $countones(rd_data) ==
         ($countones({rd_data[POLL_BIT], rd_data[TOG_BIT]})));

   // R9
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |-> rd_data == '0);

endmodule

bind poll_resp poll_resp_chk #(
   .DATA_W   (DATA_W),
   .POLL_BIT (POLL_BIT),
   .TOG_BIT  (TOG_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ce_n         (ce_n),
   .oe_n         (oe_n),
   .prog_busy    (prog_busy),
   .last_wr_byte (last_wr_byte),
   .arr_rdata    (arr_rdata),
   .rd_data      (rd_data),
   .drive_en     (drive_en)
);

// File: tb/tb_poll_resp.sv
module tb_poll_resp;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1;
   logic       oe_n = 1'b1;
   logic       prog_busy = 1'b0;
   logic [7:0] last_wr_byte = '0;
   logic [7:0] arr_rdata = '0;
   logic [7:0] rd_data;
   logic       drive_en;

   int n_chk = 0;
   int n_bad = 0;
   logic mtog = 1'b0;   // bench model of the toggle phase

   always #10 clk = ~clk;

   poll_resp dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ce_n         (ce_n),
      .oe_n         (oe_n),
      .prog_busy    (prog_busy),
      .last_wr_byte (last_wr_byte),
      .arr_rdata    (arr_rdata),
      .rd_data      (rd_data),
      .drive_en     (drive_en)
   );

   typedef struct {
      string      tag;
      logic       oe;
      logic [7:0] d;
   } exp_t;

   exp_t exp_q[$];
   event samp_ev;

   task automatic expect_now(input string tag, input logic oe, input logic [7:0] d);
      exp_t e;
      e.tag = tag; e.oe = oe; e.d = d;
      exp_q.push_back(e);
      -> samp_ev;
      #3;
   endtask

   initial begin : monitor
      forever begin
         @(samp_ev);
         #2;
         if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (drive_en !== e.oe || rd_data !== e.d)
               $display("FAIL %s: got oe=%b data=%h, expected oe=%b data=%h",
                        e.tag, drive_en, rd_data, e.oe, e.d);
            if (drive_en !== e.oe || rd_data !== e.d) n_bad++;
         end
      end
   end

   function automatic logic [7:0] busy_val(input logic [7:0] lb, input logic t);
      return {~lb[7], t, 6'b0};
   endfunction

   // full read access held for two cycles, then released
   task automatic rd_access(input string tag, input logic busy,
                            input logic [7:0] lb, input logic [7:0] arr);
      logic [7:0] ev;
      @(negedge clk);
      prog_busy = busy; last_wr_byte = lb; arr_rdata = arr;
      ce_n = 1'b0; oe_n = 1'b0;
      if (busy) mtog = ~mtog;
      ev = busy ? busy_val(lb, mtog) : arr;
      #4 expect_now({tag, " first cycle"}, 1'b1, ev);
      @(negedge clk);
      #4 expect_now({tag, " held cycle"}, 1'b1, ev);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      #4 expect_now({tag, " released R9 R1"}, 1'b0, 8'h00);
   endtask

   task automatic partial(input string tag, input logic c, input logic o);
      @(negedge clk);
      ce_n = c; oe_n = o; arr_rdata = 8'hE7;
      #4 expect_now(tag, 1'b0, 8'h00);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   initial begin : watchdog
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      #4 expect_now("R9 reset state", 1'b0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 idle reads
      rd_access("R2 idle A5", 1'b0, 8'h00, 8'hA5);
      rd_access("R2 idle 3C", 1'b0, 8'h11, 8'h3C);

      // R1 partial selects while idle
      partial("R1 ce low oe high", 1'b0, 1'b1);
      partial("R1 oe low ce high", 1'b1, 1'b0);

      // R8 R3 R5 first busy read after reset shows toggle 1
      rd_access("R8 R3 R5 busy 55", 1'b1, 8'h55, 8'hFF);
      // R4 toggle flips on next access
      rd_access("R4 busy 55 again", 1'b1, 8'h55, 8'hFF);
      rd_access("R3 R4 busy C3", 1'b1, 8'hC3, 8'h00);

      // R1 partial selects while busy do not count as accesses
      @(negedge clk); prog_busy = 1'b1;
      partial("R1 busy ce only", 1'b0, 1'b1);
      partial("R1 busy oe only", 1'b1, 1'b0);
      rd_access("R1 R4 busy after partials", 1'b1, 8'h80, 8'h00);

      // R6 programming done: true data, no toggling
      rd_access("R6 idle 96", 1'b0, 8'h80, 8'h96);
      rd_access("R6 idle 69", 1'b0, 8'h80, 8'h69);

      // R7 phase carried into next busy period
      rd_access("R7 new busy period", 1'b1, 8'h7F, 8'h00);

      // R10 busy rises during an access started idle
      @(negedge clk);
      prog_busy = 1'b0; arr_rdata = 8'h5A; last_wr_byte = 8'h2B;
      ce_n = 1'b0; oe_n = 1'b0;
      #4 expect_now("R10 idle start", 1'b1, 8'h5A);
      @(negedge clk);
      prog_busy = 1'b1;
      #4 expect_now("R10 busy mid access no flip", 1'b1, busy_val(8'h2B, mtog));
      @(negedge clk);
      #4 expect_now("R10 busy mid access held", 1'b1, busy_val(8'h2B, mtog));
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      #4 expect_now("R10 released R9", 1'b0, 8'h00);
      rd_access("R10 R4 next access flips", 1'b1, 8'h2B, 8'h00);

      @(negedge clk); prog_busy = 1'b0;
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule